// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for a stalled processor. A free-running counter advances on every clock while the watchdog is enabled. Software must "feed" it through a register write before the count reaches a programmable terminal value. When the count does reach that value, the block reacts according to one of two policies.

In the direct policy, every expiry produces a system reset at once. In the escalating policy, the first expiry raises an interrupt request and the count starts over. If that interrupt is still pending when the count expires again, the block issues the system reset. This gives software one full period to recover before the chip is reset.

The registers sit on a simple synchronous bus with a select strobe, a write flag, a byte address and 32-bit data. Reads are combinational. The reset output is a single-cycle pulse. The same pulse also returns the block's own registers to their power-on values.

Top module: `watchdog_escalator`

## Requirements
- R1: After reset, `irq` and `sysRst` are 0, the control register (offset 0x00) reads 0 and the status register (offset 0x08) reads 0x00000040.
- R2: The control register at 0x00 holds the enable bit in bit 0, the escalating-policy bit in bit 1 and a 4-bit timeout select in bits 7:4. It reads back those bits with every other bit at 0. Once enabled, the first expiry occurs 2^(BASE_EXP+select) cycles after the clock edge that wrote the enable bit.
- R3: With the escalating policy, an expiry while no interrupt is pending sets `irq` to 1 in the following cycle, does not assert `sysRst`, and restarts the count.
- R4: With the escalating policy, an expiry while the interrupt is still pending produces a `sysRst` pulse in the following cycle.
- R5: With the direct policy, every expiry produces a `sysRst` pulse in the following cycle, and `irq` stays 0.
- R6: Any write to offset 0x04 restarts the count from zero and clears the pending interrupt. This takes priority over an expiry in the same cycle, so that expiry produces neither interrupt nor reset. Offset 0x04 reads as 0.
- R7: `sysRst` lasts exactly one cycle. In the cycle after it, `irq` is 0, the control register reads 0 and the counter is stopped.
- R8: The status register at 0x08 shows the pending interrupt in bit 7, a constant 1 in bit 6 and a copy of the escalating-policy bit in bit 4. All its other bits are 0, and writes to it change nothing.
- R9: While the enable bit is 0, the count does not advance, and neither `irq` nor `sysRst` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Pending timeout interrupt |
| sysRst | output | 1 | One-cycle system reset pulse |

## Verification
The hardest case to reach is a feed write that lands on exactly the same clock edge as the second expiry in the escalating policy. The feed must win, so that no reset pulse appears. The stimulus reaches this case by counting clock edges from the edge that enabled the counter. It then starts the feed write so that its edge falls exactly two periods later. The bench also lets the block reset itself, and then checks through register reads that the control state has returned to its reset values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W = 4;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_FEED   = 8'h04;
  localparam logic [7:0] OFF_STATUS = 8'h08;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_ESC_BIT  = 1;
  localparam int CTRL_SEL_LSB  = 4;
  localparam int STAT_PEND_BIT = 7;
  localparam int STAT_ONE_BIT  = 6;
  localparam int STAT_ESC_BIT  = 4;

  typedef struct packed {
    logic             clear;
    logic             run;
    logic [SEL_W-1:0] sel;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 16,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W)
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdt_strobe_t strb,
  output logic        expire
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit  = (ONE << (BASE_EXP + int'(strb.sel))) - ONE;
    expire = strb.run && !strb.clear && (count >= limit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (!strb.run || strb.clear || expire) begin
      count <= '0;
    end else begin
      count <= count + ONE;
    end
  end

  // R6: a restart strobe leaves the count at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (count == '0));

  // R9: a stopped watchdog holds its count at zero
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (count == '0));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              expire,
  output wdt_strobe_t       strb,
  output logic              irq,
  output logic              sysRst
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_FEED   = ADDR_W'(OFF_FEED);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  logic             ctrlEn;
  logic             ctrlEsc;
  logic [SEL_W-1:0] ctrlSel;
  logic             intPend;
  logic             rstPulse;
  logic             wrCtrl;
  logic             wrFeed;
  logic             rdAny;
  logic             escalate;
  logic             unusedWdata;

  always_comb begin
    wrCtrl   = busSel && busWrite && (busAddr == A_CTRL);
    wrFeed   = busSel && busWrite && (busAddr == A_FEED);
    rdAny    = busSel && !busWrite;
    escalate = expire && !wrFeed && (!ctrlEsc || intPend);
  end

  assign unusedWdata = ^{busWdata[DATA_W-1:CTRL_SEL_LSB+SEL_W],
                         busWdata[CTRL_SEL_LSB-1:CTRL_ESC_BIT+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      ctrlEsc  <= 1'b0;
      ctrlSel  <= '0;
      intPend  <= 1'b0;
      rstPulse <= 1'b0;
    end else if (rstPulse) begin
      ctrlEn   <= 1'b0;
      ctrlEsc  <= 1'b0;
      ctrlSel  <= '0;
      intPend  <= 1'b0;
      rstPulse <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ctrlEn  <= busWdata[CTRL_EN_BIT];
        ctrlEsc <= busWdata[CTRL_ESC_BIT];
        ctrlSel <= busWdata[CTRL_SEL_LSB +: SEL_W];
      end
      if (wrFeed) begin
        intPend <= 1'b0;
      end else if (expire && ctrlEsc && !intPend) begin
        intPend <= 1'b1;
      end
      rstPulse <= escalate;
    end
  end

  always_comb begin
    strb.clear = wrFeed || rstPulse;
    strb.run   = ctrlEn;
    strb.sel   = ctrlSel;
  end

  always_comb begin
    busRdata = '0;
    if (rdAny) begin
      case (busAddr)
        A_CTRL: begin
          busRdata[CTRL_EN_BIT]                = ctrlEn;
          busRdata[CTRL_ESC_BIT]               = ctrlEsc;
          busRdata[CTRL_SEL_LSB +: SEL_W]      = ctrlSel;
        end
        A_STATUS: begin
          busRdata[STAT_PEND_BIT] = intPend;
          busRdata[STAT_ONE_BIT]  = 1'b1;
          busRdata[STAT_ESC_BIT]  = ctrlEsc;
        end
        default: busRdata = '0;
      endcase
    end
  end

  assign irq    = intPend;
  assign sysRst = rstPulse;

  // R3: first expiry in escalating policy raises the interrupt, no reset
  a_r3_first_irq: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !wrFeed && !rstPulse && ctrlEsc && !intPend) |=> (irq && !sysRst));

  // R4: expiry with the interrupt still pending escalates to reset
  a_r4_escalate: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !wrFeed && !rstPulse && ctrlEsc && intPend) |=> sysRst);

  // R5: direct policy resets on every expiry
  a_r5_direct_reset: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !wrFeed && !rstPulse && !ctrlEsc) |=> sysRst);

  // R6: a feed clears the pending interrupt and suppresses reset
  a_r6_feed_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrFeed && !rstPulse) |=> (!irq && !sysRst));

  // R7: reset pulse lasts one cycle and leaves the block idle
  a_r7_pulse_clears: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |=> (!sysRst && !irq && !strb.run));
endmodule

// File: rtl/watchdog_escalator.sv
module watchdog_escalator
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int BASE_EXP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              sysRst
);
  wdt_strobe_t strb;
  logic        expire;

  wdt_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .expire   (expire),
    .strb     (strb),
    .irq      (irq),
    .sysRst   (sysRst)
  );

  wdt_datapath #(
    .BASE_EXP (BASE_EXP)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .expire (expire)
  );
endmodule

// File: tb/test_watchdog_escalator.sv
module test_watchdog_escalator;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int BASE   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              irq;
  logic              sysRst;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int          at;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  watchdog_escalator #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .BASE_EXP (BASE)
  ) i_watchdog_escalator (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irq      (irq),
    .sysRst   (sysRst)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period(int sel);
    return 1 << (BASE + sel);
  endfunction

  task automatic expectAt(int at, int kind, logic [31:0] v, string tag);
    item_t it;
    it.at = at; it.kind = kind; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expIrq(int at, logic v, string tag);
    expectAt(at, 1, {31'b0, v}, tag);
  endtask

  task automatic expRst(int at, logic v, string tag);
    expectAt(at, 2, {31'b0, v}, tag);
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    expectAt(cyc, 0, e, tag);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1'b1;
    $finish;
  endtask

  // monitor: compares expected items when their cycle comes up
  always begin
    @(negedge clk);
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        logic [31:0] act;
        act = (q[i].kind == 0) ? busRdata :
              (q[i].kind == 1) ? {31'b0, irq} : {31'b0, sysRst};
        checks++;
        if (act !== q[i].exp) begin
          errors++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                   q[i].tag, q[i].kind, cyc, act, q[i].exp);
        end
        q.delete(i);
      end else if (q[i].at < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s missed cycle=%0d actual=none expected=%h",
                 q[i].tag, q[i].at, q[i].exp);
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    int n0;
    int f;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expIrq(cyc, 1'b0, "R1");
    expRst(cyc, 1'b0, "R1");
    rd(4'h0, 32'h0, "R1");
    rd(4'h8, 32'h40, "R1");

    // R2 R3 R4 R7: escalating policy, no feed
    wr(4'h0, 32'h03);
    n0 = cyc;
    expIrq(n0 + 15, 1'b0, "R2");
    expIrq(n0 + 16, 1'b1, "R3");
    expRst(n0 + 16, 1'b0, "R3");
    expRst(n0 + 31, 1'b0, "R4");
    expRst(n0 + 32, 1'b1, "R4");
    expIrq(n0 + 32, 1'b1, "R4");
    expRst(n0 + 33, 1'b0, "R7");
    expIrq(n0 + 33, 1'b0, "R7");
    waitUntil(n0 + 18);
    rd(4'h8, 32'hD0, "R8");
    waitUntil(n0 + 34);
    rd(4'h0, 32'h0, "R7");
    rd(4'h8, 32'h40, "R7");
    waitUntil(n0 + 80);
    expIrq(cyc, 1'b0, "R7");
    expRst(cyc, 1'b0, "R7");

    // R6: feed while interrupt pending cancels escalation
    wr(4'h0, 32'h03);
    n0 = cyc;
    waitUntil(n0 + 20);
    wr(4'h4, 32'h0);
    f = cyc;
    expIrq(f, 1'b0, "R6");
    expRst(n0 + 32, 1'b0, "R6");
    expIrq(f + 15, 1'b0, "R6");
    expIrq(f + 16, 1'b1, "R3");
    expRst(f + 16, 1'b0, "R3");
    expRst(f + 32, 1'b1, "R4");
    waitUntil(f + 34);

    // R6: feed on the same edge as the second expiry wins
    wr(4'h0, 32'h03);
    n0 = cyc;
    waitUntil(n0 + period(0) * 2 - 2);
    wr(4'h4, 32'h0);
    expRst(n0 + 32, 1'b0, "R6");
    expIrq(n0 + 32, 1'b0, "R6");
    expIrq(n0 + 48, 1'b1, "R6");
    expRst(n0 + 48, 1'b0, "R6");
    expRst(n0 + 64, 1'b1, "R6");
    waitUntil(n0 + 66);

    // R5 R2: direct policy, select 1
    wr(4'h0, 32'h11);
    n0 = cyc;
    expRst(n0 + period(1) - 1, 1'b0, "R2");
    expRst(n0 + period(1), 1'b1, "R5");
    expIrq(n0 + period(1), 1'b0, "R5");
    expRst(n0 + period(1) + 1, 1'b0, "R7");
    waitUntil(n0 + period(1) + 2);
    rd(4'h0, 32'h0, "R7");

    // R2 R6: direct policy, select 2, fed once
    wr(4'h0, 32'h21);
    n0 = cyc;
    waitUntil(n0 + 48);
    wr(4'h4, 32'h0);
    f = cyc;
    expRst(n0 + period(2), 1'b0, "R6");
    expRst(f + period(2) - 1, 1'b0, "R2");
    expRst(f + period(2), 1'b1, "R2");
    waitUntil(f + period(2) + 2);

    // R9: disabled, escalating bit set
    wr(4'h0, 32'h02);
    n0 = cyc;
    expIrq(n0 + 16, 1'b0, "R9");
    expRst(n0 + 32, 1'b0, "R9");
    expIrq(n0 + 100, 1'b0, "R9");
    expRst(n0 + 100, 1'b0, "R9");
    rd(4'h8, 32'h50, "R8");
    waitUntil(n0 + 101);

    // R8 R2: status writes ignored, control field masking
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, 32'h50, "R8");
    rd(4'h0, 32'h02, "R8");
    wr(4'h0, 32'hFFFF_FFFE);
    rd(4'h0, 32'hF2, "R2");
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h0, "R2");
    rd(4'h4, 32'h0, "R6");

    waitUntil(cyc + 3);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL leftover actual=%0d expected=0", q.size());
    end
    report();
  end
endmodule